// File: doc/BRIEF.md
# ADC Conversion Clock Selector and Prescaler

This block generates the conversion clock for an analog-to-digital converter core. It chooses between two sources. The first is an independent kernel clock, which passes through a prescaler with twelve legal ratios from 1 to 256. The second is the bus clock, which is divided by 2 or by 4, or passed through unchanged. A configuration write on the bus clock sets a 2-bit source-mode field, a 4-bit prescaler code and a low-frequency-mode flag. A write is taken only while the converter enable is low.

Alongside the clock, the block reports whether the trigger-to-start latency is fixed, which is true only for the bus-clock modes. It also gives that latency in eighths of a conversion cycle. A low-frequency warning rises when the nominal output frequency falls below 3.5 MHz while the low-frequency flag is clear. The nominal output frequency is computed from parameters that give the two source frequencies in kHz. A configuration-error flag marks prescaler codes that are out of range.

Top module: `adc_clk_sel`

## Requirements
- R1: With mode 00 the output follows the kernel path. Prescaler codes 0 to 11 give ratios 1, 2, 4, 6, 8, 10, 12, 16, 32, 64, 128 and 256 in that order. Code 0 passes the kernel clock straight through.
- R2: Mode 01 outputs the bus clock divided by 2. Mode 10 outputs the bus clock divided by 4. Mode 11 passes the bus clock straight through.
- R3: Every divided output is high for N/2 source cycles and then low for N/2 source cycles, where N is the selected ratio.
- R4: latDeterministic is 0 in mode 00 and 1 in modes 01, 10 and 11.
- R5: latencyEighths reads 34 in mode 01, 33 in mode 10 and 36 in mode 11. It reads 0 in mode 00.
- R6: Prescaler codes 12 to 15 divide the kernel clock by 256 and assert cfgError. Codes 0 to 11 leave cfgError low.
- R7: lowFreqError is 1 exactly when the low-frequency flag is clear and the nominal output frequency in kHz is strictly below the limit (default 3500). A frequency equal to the limit raises no error.
- R8: A configuration write takes effect at the busClk edge where cfgWrite is 1 and adcEnable is 0. A write made while adcEnable is 1 changes neither the outputs nor the flags.
- R9: When the mode field changes, the bus divider counter restarts from zero. When the prescaler code changes, the kernel divider counter restarts from zero. After an accepted mode change, the divided output is high for the first N/2 bus cycles.
- R10: After reset the configuration is mode 00, code 0 and flag clear. The output then follows the kernel clock, and all status flags and the latency value are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| busClk | input | 1 | Bus clock; configuration clock and bus-path source |
| kerClk | input | 1 | Independent kernel clock source |
| rst_n | input | 1 | Asynchronous active-low reset |
| adcEnable | input | 1 | Converter enable; blocks configuration writes while high |
| cfgWrite | input | 1 | Configuration write strobe |
| cfgMode | input | 2 | Source mode: 00 kernel, 01 bus/2, 10 bus/4, 11 bus/1 |
| cfgPresc | input | 4 | Kernel prescaler code |
| cfgLowFreq | input | 1 | Low-frequency-mode flag |
| adcClk | output | 1 | Selected conversion clock |
| latDeterministic | output | 1 | Trigger latency is fixed |
| latencyEighths | output | 6 | Fixed trigger latency in eighths of a cycle |
| lowFreqError | output | 1 | Output below limit with low-frequency flag clear |
| cfgError | output | 1 | Prescaler code out of range |

## Verification
The bench sets the kernel frequency to 14000 kHz and the bus frequency to 7000 kHz. With these values, a kernel divide by 4 and a bus divide by 2 both land exactly on the 3500 kHz limit. The next step down on either path falls just below the limit. Both sides of the strict comparison can therefore be reached with ordinary mode and prescaler codes. The kernel and bus clocks run at different periods, so each divided output is measured in cycles of its own source.

// File: rtl/adcclk_pkg.sv
package adcclk_pkg;
  localparam int unsigned MAX_RATIO = 256;
  localparam int unsigned RATIO_W   = $clog2(MAX_RATIO) + 1;
  localparam int unsigned CNT_W     = $clog2(MAX_RATIO);
  localparam int unsigned LAT_W     = 6;
  localparam int unsigned CODE_W    = 4;
  localparam int unsigned LEGAL_CODES = 12;

  typedef enum logic [1:0] {
    SRC_KER    = 2'b00,
    SRC_BUS_D2 = 2'b01,
    SRC_BUS_D4 = 2'b10,
    SRC_BUS_D1 = 2'b11
  } srcMode_e;

  // Strobes and selects handed from control to datapath
  typedef struct packed {
    logic               busClr;
    logic               selKer;
    logic               kerBypass;
    logic               busBypass;
    logic [RATIO_W-1:0] busRatio;
    logic [CODE_W-1:0]  prescCode;
  } dpCtrl_t;

  function automatic logic [RATIO_W-1:0] prescRatio(input logic [CODE_W-1:0] code);
    logic [RATIO_W-1:0] r;
    case (code)
      4'd0:    r = RATIO_W'(1);
      4'd1:    r = RATIO_W'(2);
      4'd2:    r = RATIO_W'(4);
      4'd3:    r = RATIO_W'(6);
      4'd4:    r = RATIO_W'(8);
      4'd5:    r = RATIO_W'(10);
      4'd6:    r = RATIO_W'(12);
      4'd7:    r = RATIO_W'(16);
      4'd8:    r = RATIO_W'(32);
      4'd9:    r = RATIO_W'(64);
      4'd10:   r = RATIO_W'(128);
      default: r = RATIO_W'(MAX_RATIO);
    endcase
    return r;
  endfunction

  function automatic logic [LAT_W-1:0] latEighths(input srcMode_e m);
    logic [LAT_W-1:0] v;
    case (m)
      SRC_BUS_D2: v = LAT_W'(34);
      SRC_BUS_D4: v = LAT_W'(33);
      SRC_BUS_D1: v = LAT_W'(36);
      default:    v = '0;
    endcase
    return v;
  endfunction

  function automatic logic [RATIO_W-1:0] busDivisor(input srcMode_e m);
    logic [RATIO_W-1:0] v;
    case (m)
      SRC_BUS_D2: v = RATIO_W'(2);
      SRC_BUS_D4: v = RATIO_W'(4);
      default:    v = RATIO_W'(1);
    endcase
    return v;
  endfunction
endpackage

// File: rtl/adcclk_div.sv
module adcclk_div
  import adcclk_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic [RATIO_W-1:0] ratio,
  output logic               divOut
);
  logic [CNT_W-1:0]   cnt;
  logic [CNT_W-1:0]   cntNext;
  logic [RATIO_W-1:0] half;
  logic               lastStep;

  assign half     = ratio >> 1;
  assign lastStep = (RATIO_W'(cnt) + RATIO_W'(1)) >= ratio;

  always_comb begin
    if (clr || lastStep) cntNext = '0;
    else                 cntNext = cnt + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      divOut <= 1'b1;
    end else begin
      cnt    <= cntNext;
      divOut <= RATIO_W'(cntNext) < half;
    end
  end

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |-> (RATIO_W'(cnt) < ratio)); // R9
  AST_WRAP_GOES_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && ratio > RATIO_W'(1) && RATIO_W'(cnt) == ratio - RATIO_W'(1)) |=> divOut); // R3
  AST_CLR_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt == '0)); // R9
endmodule

// File: rtl/adcclk_ctrl.sv
module adcclk_ctrl
  import adcclk_pkg::*;
#(
  parameter int unsigned KER_KHZ      = 16000,
  parameter int unsigned BUS_KHZ      = 32000,
  parameter int unsigned LF_LIMIT_KHZ = 3500
) (
  input  logic              busClk,
  input  logic              rst_n,
  input  logic              adcEnable,
  input  logic              cfgWrite,
  input  logic [1:0]        cfgMode,
  input  logic [CODE_W-1:0] cfgPresc,
  input  logic              cfgLowFreq,
  output dpCtrl_t           ctl,
  output logic              latDeterministic,
  output logic [LAT_W-1:0]  latencyEighths,
  output logic              lowFreqError,
  output logic              cfgError
);
  srcMode_e          modeQ;
  logic [CODE_W-1:0] prescQ;
  logic              lfQ;
  logic              busClrQ;
  logic              wrAccept;
  srcMode_e          modeIn;
  logic [31:0]       srcKhz;
  logic [31:0]       needKhz;
  logic [RATIO_W-1:0] effRatio;

  assign modeIn   = srcMode_e'(cfgMode);
  assign wrAccept = cfgWrite && !adcEnable;

  always_ff @(posedge busClk or negedge rst_n) begin
    if (!rst_n) begin
      modeQ   <= SRC_KER;
      prescQ  <= '0;
      lfQ     <= 1'b0;
      busClrQ <= 1'b0;
    end else begin
      busClrQ <= wrAccept && (modeIn != modeQ);
      if (wrAccept) begin
        modeQ  <= modeIn;
        prescQ <= cfgPresc;
        lfQ    <= cfgLowFreq;
      end
    end
  end

  // Nominal output frequency check done as srcKhz < limit * ratio
  always_comb begin
    if (modeQ == SRC_KER) begin
      srcKhz   = KER_KHZ;
      effRatio = prescRatio(prescQ);
    end else begin
      srcKhz   = BUS_KHZ;
      effRatio = busDivisor(modeQ);
    end
    needKhz = LF_LIMIT_KHZ * 32'(effRatio);
  end

  assign lowFreqError     = !lfQ && (srcKhz < needKhz);
  assign cfgError         = prescQ >= CODE_W'(LEGAL_CODES);
  assign latDeterministic = modeQ != SRC_KER;
  assign latencyEighths   = latEighths(modeQ);

  always_comb begin
    ctl           = '0;
    ctl.busClr    = busClrQ;
    ctl.selKer    = modeQ == SRC_KER;
    ctl.kerBypass = prescQ == '0;
    ctl.busBypass = modeQ == SRC_BUS_D1;
    ctl.busRatio  = (modeQ == SRC_BUS_D4) ? RATIO_W'(4) : RATIO_W'(2);
    ctl.prescCode = prescQ;
  end

  AST_HOLD_WHILE_ENABLED: assert property (@(posedge busClk) disable iff (!rst_n)
    adcEnable |=> ($stable(modeQ) && $stable(prescQ) && $stable(lfQ))); // R8
  AST_CLR_ON_MODE_CHANGE: assert property (@(posedge busClk) disable iff (!rst_n)
    (modeQ != $past(modeQ)) |-> busClrQ); // R9
  AST_LAT_WHEN_FIXED: assert property (@(posedge busClk) disable iff (!rst_n)
    latDeterministic |-> (latencyEighths inside {6'd33, 6'd34, 6'd36})); // R5
  AST_LAT_WHEN_ASYNC: assert property (@(posedge busClk) disable iff (!rst_n)
    !latDeterministic |-> (latencyEighths == '0)); // R4
endmodule

// File: rtl/adcclk_dp.sv
module adcclk_dp
  import adcclk_pkg::*;
(
  input  logic    busClk,
  input  logic    kerClk,
  input  logic    rst_n,
  input  dpCtrl_t ctl,
  output logic    adcClk
);
  logic [CODE_W-1:0]  codeS1;
  logic [CODE_W-1:0]  codeS2;
  logic               kerClrQ;
  logic [RATIO_W-1:0] kerRatio;
  logic               kerDiv;
  logic               busDiv;

  // Prescaler code brought into the kernel domain; only changes while idle
  always_ff @(posedge kerClk or negedge rst_n) begin
    if (!rst_n) begin
      codeS1  <= '0;
      codeS2  <= '0;
      kerClrQ <= 1'b0;
    end else begin
      codeS1  <= ctl.prescCode;
      codeS2  <= codeS1;
      kerClrQ <= codeS1 != codeS2;
    end
  end

  assign kerRatio = prescRatio(codeS2);

  adcclk_div u_kerDiv (
    .clk   (kerClk),
    .rst_n (rst_n),
    .clr   (kerClrQ),
    .ratio (kerRatio),
    .divOut(kerDiv)
  );

  adcclk_div u_busDiv (
    .clk   (busClk),
    .rst_n (rst_n),
    .clr   (ctl.busClr),
    .ratio (ctl.busRatio),
    .divOut(busDiv)
  );

  always_comb begin
    if (ctl.selKer) adcClk = ctl.kerBypass ? kerClk : kerDiv;
    else            adcClk = ctl.busBypass ? busClk : busDiv;
  end

  AST_KER_CLR_ON_CODE_CHANGE: assert property (@(posedge kerClk) disable iff (!rst_n)
    (codeS2 != $past(codeS2)) |-> kerClrQ); // R9
endmodule

// File: rtl/adc_clk_sel.sv
module adc_clk_sel
  import adcclk_pkg::*;
#(
  parameter int unsigned KER_KHZ      = 16000,
  parameter int unsigned BUS_KHZ      = 32000,
  parameter int unsigned LF_LIMIT_KHZ = 3500
) (
  input  logic       busClk,
  input  logic       kerClk,
  input  logic       rst_n,
  input  logic       adcEnable,
  input  logic       cfgWrite,
  input  logic [1:0] cfgMode,
  input  logic [3:0] cfgPresc,
  input  logic       cfgLowFreq,
  output logic       adcClk,
  output logic       latDeterministic,
  output logic [5:0] latencyEighths,
  output logic       lowFreqError,
  output logic       cfgError
);
  dpCtrl_t ctl;

  adcclk_ctrl #(
    .KER_KHZ     (KER_KHZ),
    .BUS_KHZ     (BUS_KHZ),
    .LF_LIMIT_KHZ(LF_LIMIT_KHZ)
  ) u_ctrl (
    .busClk          (busClk),
    .rst_n           (rst_n),
    .adcEnable       (adcEnable),
    .cfgWrite        (cfgWrite),
    .cfgMode         (cfgMode),
    .cfgPresc        (cfgPresc),
    .cfgLowFreq      (cfgLowFreq),
    .ctl             (ctl),
    .latDeterministic(latDeterministic),
    .latencyEighths  (latencyEighths),
    .lowFreqError    (lowFreqError),
    .cfgError        (cfgError)
  );

  adcclk_dp u_dp (
    .busClk(busClk),
    .kerClk(kerClk),
    .rst_n (rst_n),
    .ctl   (ctl),
    .adcClk(adcClk)
  );
endmodule

// File: tb/adc_clk_sel_tb.sv
module adc_clk_sel_tb;
  localparam int KER_KHZ = 14000;
  localparam int BUS_KHZ = 7000;
  localparam int LIMIT   = 3500;

  logic busClk = 1'b0;
  logic kerClk = 1'b0;
  logic rst_n = 1'b0;
  logic adcEnable = 1'b0;
  logic cfgWrite = 1'b0;
  logic [1:0] cfgMode = '0;
  logic [3:0] cfgPresc = '0;
  logic cfgLowFreq = 1'b0;
  logic adcClk, latDeterministic, lowFreqError, cfgError;
  logic [5:0] latencyEighths;

  always #2 busClk = ~busClk;  // 250 MHz
  always #3 kerClk = ~kerClk;

  adc_clk_sel #(.KER_KHZ(KER_KHZ), .BUS_KHZ(BUS_KHZ), .LF_LIMIT_KHZ(LIMIT)) u_dut (
    .busClk(busClk), .kerClk(kerClk), .rst_n(rst_n), .adcEnable(adcEnable),
    .cfgWrite(cfgWrite), .cfgMode(cfgMode), .cfgPresc(cfgPresc), .cfgLowFreq(cfgLowFreq),
    .adcClk(adcClk), .latDeterministic(latDeterministic), .latencyEighths(latencyEighths),
    .lowFreqError(lowFreqError), .cfgError(cfgError)
  );

  typedef struct {
    string tag;
    bit    useKer;
    int    ratio;
    bit    det;
    int    lat;
    bit    lfErr;
    bit    cfgErr;
  } exp_t;

  exp_t expQ[$];
  event measReq, measDone;
  int checks = 0;
  int errors = 0;

  task automatic chk(string tag, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic int tbRatio(int code);
    int tbl[12] = '{1, 2, 4, 6, 8, 10, 12, 16, 32, 64, 128, 256};
    return (code < 12) ? tbl[code] : 256;
  endfunction

  task automatic waitPos(bit k);
    if (k) @(posedge kerClk); else @(posedge busClk);
    #1;
  endtask

  task automatic waitNeg(bit k);
    if (k) @(negedge kerClk); else @(negedge busClk);
    #1;
  endtask

  // Monitor: pops an expected item and measures the design against it
  task automatic measure(exp_t e);
    int hi, lo, guard;
    bit prev, cur, found, ok;
    chk(e.tag, int'(latDeterministic), int'(e.det), "latDeterministic");
    chk(e.tag, int'(latencyEighths), e.lat, "latencyEighths");
    chk(e.tag, int'(lowFreqError), int'(e.lfErr), "lowFreqError");
    chk(e.tag, int'(cfgError), int'(e.cfgErr), "cfgError");
    if (e.ratio == 1) begin
      ok = 1'b1;
      for (int i = 0; i < 4; i++) begin
        waitPos(e.useKer);
        if (adcClk !== 1'b1) ok = 1'b0;
        waitNeg(e.useKer);
        if (adcClk !== 1'b0) ok = 1'b0;
      end
      chk(e.tag, int'(ok), 1, "pass-through follows source");
    end else begin
      waitPos(e.useKer);
      prev = adcClk;
      found = 1'b0;
      guard = 0;
      while (!found && guard < 2 * e.ratio + 4) begin
        waitPos(e.useKer);
        cur = adcClk;
        if (!prev && cur) found = 1'b1;
        prev = cur;
        guard++;
      end
      hi = 1;
      lo = 0;
      if (found) begin
        waitPos(e.useKer);
        while (adcClk === 1'b1 && hi < 600) begin hi++; waitPos(e.useKer); end
        lo = 1;
        waitPos(e.useKer);
        while (adcClk === 1'b0 && lo < 600) begin lo++; waitPos(e.useKer); end
      end
      chk(e.tag, hi, e.ratio / 2, "R3 high phase source cycles");
      chk(e.tag, lo, e.ratio / 2, "R3 low phase source cycles");
    end
  endtask

  initial begin
    forever begin
      @(measReq);
      if (expQ.size() > 0) measure(expQ.pop_front());
      -> measDone;
    end
  end

  // Driver
  task automatic applyCfg(bit [1:0] m, bit [3:0] p, bit lf);
    @(negedge busClk);
    cfgMode = m; cfgPresc = p; cfgLowFreq = lf; cfgWrite = 1'b1;
    @(negedge busClk);
    cfgWrite = 1'b0;
    repeat (12) @(negedge busClk);
  endtask

  task automatic expectCfg(string tag, bit [1:0] m, bit [3:0] p, bit lf);
    exp_t e;
    int srcK;
    e.tag    = tag;
    e.useKer = (m == 2'b00);
    e.ratio  = e.useKer ? tbRatio(int'(p)) : (m == 2'b01 ? 2 : (m == 2'b10 ? 4 : 1));
    e.det    = (m != 2'b00);
    e.lat    = (m == 2'b01) ? 34 : (m == 2'b10) ? 33 : (m == 2'b11) ? 36 : 0;
    srcK     = e.useKer ? KER_KHZ : BUS_KHZ;
    e.lfErr  = !lf && (srcK < LIMIT * e.ratio);
    e.cfgErr = (p >= 4'd12);
    expQ.push_back(e);
    -> measReq;
    @(measDone);
  endtask

  task automatic runCase(string tag, bit [1:0] m, bit [3:0] p, bit lf);
    applyCfg(m, p, lf);
    expectCfg(tag, m, p, lf);
  endtask

  task automatic report();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge busClk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    report();
  end

  initial begin
    repeat (5) @(negedge busClk);
    rst_n = 1'b1;
    repeat (4) @(negedge busClk);
    expectCfg("R10", 2'b00, 4'd0, 1'b0);  // R10 reset state

    for (int c = 0; c < 12; c++)          // R1 full ratio table
      runCase("R1", 2'b00, 4'(c), 1'b1);

    runCase("R2", 2'b01, 4'd0, 1'b1);     // R2 R4 R5 bus modes
    runCase("R2", 2'b10, 4'd0, 1'b1);
    runCase("R2", 2'b11, 4'd0, 1'b1);
    runCase("R4", 2'b00, 4'd1, 1'b0);

    runCase("R6", 2'b00, 4'd12, 1'b1);    // R6 out-of-range codes
    runCase("R6", 2'b00, 4'd15, 1'b1);
    runCase("R6", 2'b00, 4'd5, 1'b1);

    runCase("R7", 2'b00, 4'd2, 1'b0);     // R7 exactly at limit
    runCase("R7", 2'b00, 4'd3, 1'b0);     // below limit
    runCase("R7", 2'b01, 4'd0, 1'b0);     // bus at limit
    runCase("R7", 2'b10, 4'd0, 1'b0);     // bus below limit
    runCase("R7", 2'b10, 4'd0, 1'b1);     // flag set clears warning
    runCase("R7", 2'b11, 4'd0, 1'b0);

    // R8: write while enabled is ignored
    runCase("R8", 2'b01, 4'd0, 1'b1);
    @(negedge busClk) adcEnable = 1'b1;
    applyCfg(2'b10, 4'd13, 1'b0);
    expectCfg("R8", 2'b01, 4'd0, 1'b1);
    @(negedge busClk) adcEnable = 1'b0;
    runCase("R8", 2'b11, 4'd0, 1'b1);

    // R9: mode change restarts bus divider with a full high phase
    runCase("R9", 2'b01, 4'd0, 1'b1);
    @(negedge busClk);
    cfgMode = 2'b10; cfgWrite = 1'b1;
    @(posedge busClk);
    #1 cfgWrite = 1'b0;
    for (int i = 0; i < 4; i++) begin
      @(posedge busClk);
      #1 chk("R9", int'(adcClk), (i < 2) ? 1 : 0, "restart pattern after mode change");
    end

    report();
  end
endmodule